// File: doc/BRIEF.md
# Multi-Width Ternary Search Array

This block is a synchronous, pipelined ternary search memory. Its bank is a row of 68-bit storage slots; each slot holds a data word, a per-bit care mask, a width code and a valid flag. A slot can serve alone as one 68-bit entry or as two 34-bit half entries. Two or four aligned slots can also be joined into a 136-bit or 272-bit entry. Tables of all four widths may share the bank, because every search names the width it wants and only entries tagged with that width take part.

A single write port loads either one slot or one of several global mask registers. Each search supplies a key, a width and the number of a global mask register. That register removes chosen key bit positions from the compare. The array answers with a hit flag and the lowest matching entry index, counted in units of the requested width. Searches of 68 and 136 bits may be issued on every cycle. A search of 34 or 272 bits makes the array refuse input for the following cycle.

Top module: `tsa_search_array`

## Requirements
- R1: A slot write (wr_en=1, wr_gmr=0) stores wr_data, wr_mask, wr_width and wr_valid at slot wr_addr. A stored mask bit of 0 makes that bit a don't-care. A mask bit of 1 requires the stored bit to equal the key bit.
- R2: Width codes are 0=34, 1=68, 2=136, 3=272 bits. A 136-bit entry k uses slots 2k and 2k+1. A 272-bit entry k uses slots 4k to 4k+3. Slot 4k+j (or 2k+j) is compared with key bits [68j+67:68j]. An entry matches only when every slot in its aligned group is valid and carries the requested width code.
- R3: In 34-bit mode each slot tagged 34 holds two entries. Index 2s is slot s bits [33:0] and index 2s+1 is slot s bits [67:34]. Both halves are compared with key bits [33:0], using bits [33:0] of the chosen global mask.
- R4: A write with wr_gmr=1 loads wr_data into global mask register wr_addr (low bits). A search uses the register named by srch_gmr. Where that register holds a 0, the key bit at the same position in every 68-bit segment is excluded from the compare. All registers reset to all ones.
- R5: When several entries match, the lowest index is returned. The index is in units of the requested width.
- R6: Entries tagged with a width other than the requested one never match, even if their bits agree.
- R7: A search is accepted when srch_valid and srch_ready are both 1. Its res_valid, res_hit and res_index appear right after the third rising edge, counting the edge that accepts it.
- R8: srch_ready stays 1 after an accepted 68- or 136-bit search, so one search per cycle is taken. srch_ready is 0 for exactly one cycle after an accepted 34- or 272-bit search.
- R9: A search presented while srch_ready is 0 is ignored and produces no result.
- R10: A search accepted one cycle after a slot write sees the written slot. A write accepted after a search was accepted does not change that search's result.
- R11: After reset srch_ready is 1 and res_valid is 0, every slot is invalid, and a search finds nothing.
- R12: A search with no match returns res_valid=1, res_hit=0 and res_index=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_gmr | input | 1 | 1 selects a global mask register, 0 selects a slot |
| wr_addr | input | SLOT_AW (6) | Slot number, or mask register number in the low bits |
| wr_data | input | SLOT_W (68) | Slot data or global mask value |
| wr_mask | input | SLOT_W (68) | Per-bit care mask of the slot |
| wr_width | input | 2 | Width code stored with the slot |
| wr_valid | input | 1 | Valid flag stored with the slot |
| srch_valid | input | 1 | Search request |
| srch_width | input | 2 | Requested width code |
| srch_gmr | input | GMR_AW (3) | Global mask register used by this search |
| srch_key | input | 4*SLOT_W (272) | Search key |
| srch_ready | output | 1 | Array accepts a search this cycle |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | At least one entry matched |
| res_index | output | IDX_W (7) | Lowest matching entry index |

## Verification
The bench builds the array with 16 slots and 4 global mask registers. At that size a 272-bit entry can occupy the last aligned group of four slots, and 34-bit indices reach the top of their range. The 136-bit entries, partial groups and mixed-width neighbours also fit side by side within a few writes. With so few slots, priority between overlapping entries and the ternary and global masking can be checked on hand-picked words. The same small bank still covers back-to-back issue, the idle slot forced after wide or narrow searches, and the order between a write and a search.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

  typedef enum logic [1:0] {
    TW34  = 2'd0,
    TW68  = 2'd1,
    TW136 = 2'd2,
    TW272 = 2'd3
  } tw_e;

  function automatic logic half_rate(input tw_e w);
    return (w == TW34) || (w == TW272);
  endfunction

endpackage

// File: rtl/tsa_key_stage.sv
module tsa_key_stage
  import tsa_pkg::*;
#(
  parameter int SLOT_W = 68,
  parameter int GMR_N  = 8,
  localparam int GMR_AW = $clog2(GMR_N),
  localparam int HALF_W = SLOT_W / 2,
  localparam int KEY_W  = 4 * SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gmr_we,
  input  logic [GMR_AW-1:0] gmr_addr,
  input  logic [SLOT_W-1:0] gmr_data,
  input  logic              in_valid,
  input  tw_e               in_width,
  input  logic [GMR_AW-1:0] in_sel,
  input  logic [KEY_W-1:0]  in_key,
  output logic              s1_valid,
  output tw_e               s1_width,
  output logic [KEY_W-1:0]  s1_key,
  output logic [SLOT_W-1:0] s1_care
);

  logic [SLOT_W-1:0] gmr [GMR_N];
  logic [SLOT_W-1:0] sel_mask, care_n;
  logic [KEY_W-1:0]  key_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < GMR_N; i++) gmr[i] <= '1;
    end else if (gmr_we) begin
      gmr[gmr_addr] <= gmr_data;
    end
  end

  always_comb begin
    sel_mask = gmr[in_sel];
    if (in_width == TW34) begin
      care_n = {sel_mask[HALF_W-1:0], sel_mask[HALF_W-1:0]};
      key_n  = {8{in_key[HALF_W-1:0]}};
    end else begin
      care_n = sel_mask;
      key_n  = in_key;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    s1_width <= in_width;
    s1_key   <= key_n;
    s1_care  <= care_n;
  end

  // R4: freshly reset mask registers exclude nothing
  p_gmr_reset_ones_r4: assert property (@(posedge clk)
    $past(rst) |-> (gmr[0] == '1));

endmodule

// File: rtl/tsa_slot_bank.sv
module tsa_slot_bank
  import tsa_pkg::*;
#(
  parameter int SLOTS  = 64,
  parameter int SLOT_W = 68,
  localparam int SLOT_AW = $clog2(SLOTS),
  localparam int HALF_W  = SLOT_W / 2,
  localparam int KEY_W   = 4 * SLOT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SLOT_AW-1:0] wr_addr,
  input  logic [SLOT_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0]  wr_mask,
  input  tw_e                wr_width,
  input  logic               wr_valid,
  input  logic               s1_valid,
  input  tw_e                s1_width,
  input  logic [KEY_W-1:0]   s1_key,
  input  logic [SLOT_W-1:0]  s1_care,
  output logic               s2_valid,
  output tw_e                s2_width,
  output logic [SLOTS-1:0]   lo_hit,
  output logic [SLOTS-1:0]   hi_hit
);

  logic [SLOT_W-1:0] dat [SLOTS];
  logic [SLOT_W-1:0] msk [SLOTS];
  tw_e               tag [SLOTS];
  logic [SLOTS-1:0]  vld;
  logic [SLOTS-1:0]  lo_n, hi_n;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      dat[wr_addr] <= wr_data;
      msk[wr_addr] <= wr_mask;
      tag[wr_addr] <= wr_width;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_en) vld[wr_addr] <= wr_valid;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [1:0]        seg;
    logic [SLOT_W-1:0] kseg, bit_ok;
    logic              live;
    assign seg    = (s1_width == TW136) ? 2'(s % 2) :
                    (s1_width == TW272) ? 2'(s % 4) : 2'd0;
    assign kseg   = s1_key[seg*SLOT_W +: SLOT_W];
    assign bit_ok = ~s1_care | ~msk[s] | ~(dat[s] ^ kseg);
    assign live   = vld[s] && (tag[s] == s1_width);
    assign lo_n[s] = live && (&bit_ok[HALF_W-1:0]);
    assign hi_n[s] = live && (&bit_ok[SLOT_W-1:HALF_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    s2_width <= s1_width;
    lo_hit   <= lo_n;
    hi_hit   <= hi_n;
  end

  // R11: no slot may report a match right after reset
  p_empty_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld == '0));

endmodule

// File: rtl/tsa_resolve.sv
module tsa_resolve
  import tsa_pkg::*;
#(
  parameter int SLOTS = 64,
  localparam int CAND_N = 2 * SLOTS,
  localparam int IDX_W  = $clog2(CAND_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s2_valid,
  input  tw_e              s2_width,
  input  logic [SLOTS-1:0] lo_hit,
  input  logic [SLOTS-1:0] hi_hit,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_index
);

  logic [SLOTS-1:0]  full;
  logic [CAND_N-1:0] cand;
  logic              found;
  logic [IDX_W-1:0]  idx;

  assign full = lo_hit & hi_hit;

  always_comb begin
    cand = '0;
    unique case (s2_width)
      TW34: for (int i = 0; i < SLOTS; i++) begin
        cand[2*i]   = lo_hit[i];
        cand[2*i+1] = hi_hit[i];
      end
      TW68: for (int i = 0; i < SLOTS; i++) cand[i] = full[i];
      TW136: for (int i = 0; i < SLOTS/2; i++)
        cand[i] = full[2*i] & full[2*i+1];
      TW272: for (int i = 0; i < SLOTS/4; i++)
        cand[i] = &full[4*i +: 4];
    endcase
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = CAND_N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_index <= '0;
    end else begin
      res_valid <= s2_valid;
      res_hit   <= s2_valid && found;
      res_index <= (s2_valid && found) ? idx : '0;
    end
  end

  p_hit_when_candidate_r5: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && (cand != '0)) |=> res_hit);
  p_miss_reports_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && (cand == '0)) |=> (!res_hit && res_index == '0));
  p_lowest_first_r5: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && cand[0]) |=> (res_index == '0));

endmodule

// File: rtl/tsa_search_array.sv
module tsa_search_array
  import tsa_pkg::*;
#(
  parameter int SLOTS  = 64,
  parameter int SLOT_W = 68,
  parameter int GMR_N  = 8,
  localparam int SLOT_AW = $clog2(SLOTS),
  localparam int GMR_AW  = $clog2(GMR_N),
  localparam int IDX_W   = $clog2(2 * SLOTS),
  localparam int KEY_W   = 4 * SLOT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_gmr,
  input  logic [SLOT_AW-1:0] wr_addr,
  input  logic [SLOT_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0]  wr_mask,
  input  logic [1:0]         wr_width,
  input  logic               wr_valid,
  input  logic               srch_valid,
  input  logic [1:0]         srch_width,
  input  logic [GMR_AW-1:0]  srch_gmr,
  input  logic [KEY_W-1:0]   srch_key,
  output logic               srch_ready,
  output logic               res_valid,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_index
);

  logic             accept;
  tw_e              req_w;
  logic             s1_valid, s2_valid;
  tw_e              s1_width, s2_width;
  logic [KEY_W-1:0] s1_key;
  logic [SLOT_W-1:0] s1_care;
  logic [SLOTS-1:0] lo_hit, hi_hit;
  logic [1:0]       age;

  assign req_w  = tw_e'(srch_width);
  assign accept = srch_valid && srch_ready;

  always_ff @(posedge clk) begin
    if (rst)         srch_ready <= 1'b1;
    else if (accept) srch_ready <= !half_rate(req_w);
    else             srch_ready <= 1'b1;
  end

  tsa_key_stage #(.SLOT_W(SLOT_W), .GMR_N(GMR_N)) i_key (
    .clk(clk), .rst(rst),
    .gmr_we(wr_en && wr_gmr), .gmr_addr(wr_addr[GMR_AW-1:0]), .gmr_data(wr_data),
    .in_valid(accept), .in_width(req_w), .in_sel(srch_gmr), .in_key(srch_key),
    .s1_valid(s1_valid), .s1_width(s1_width), .s1_key(s1_key), .s1_care(s1_care)
  );

  tsa_slot_bank #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) i_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en && !wr_gmr), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .wr_width(tw_e'(wr_width)), .wr_valid(wr_valid),
    .s1_valid(s1_valid), .s1_width(s1_width), .s1_key(s1_key), .s1_care(s1_care),
    .s2_valid(s2_valid), .s2_width(s2_width), .lo_hit(lo_hit), .hi_hit(hi_hit)
  );

  tsa_resolve #(.SLOTS(SLOTS)) i_resolve (
    .clk(clk), .rst(rst),
    .s2_valid(s2_valid), .s2_width(s2_width), .lo_hit(lo_hit), .hi_hit(hi_hit),
    .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index)
  );

  // cycles since reset, saturating, so the latency check never looks before reset
  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_idle_after_half_rate_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && half_rate(req_w)) |=> !srch_ready);
  p_full_rate_keeps_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && !half_rate(req_w)) |=> srch_ready);
  p_ready_recovers_r8: assert property (@(posedge clk) disable iff (rst)
    !srch_ready |=> srch_ready);
  // R9 as well: refused searches leave no result three edges later
  p_fixed_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (res_valid == $past(accept, 3)));
  p_hit_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);

endmodule

// File: tb/test_tsa_search_array.sv
module test_tsa_search_array;
  localparam int SLOTS = 16, SLOT_W = 68, GMR_N = 4;
  localparam int SLOT_AW = $clog2(SLOTS), GMR_AW = $clog2(GMR_N);
  localparam int IDX_W = $clog2(2 * SLOTS), KEY_W = 4 * SLOT_W;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_gmr = 0, wr_valid = 0, srch_valid = 0;
  logic [SLOT_AW-1:0] wr_addr = '0;
  logic [SLOT_W-1:0]  wr_data = '0, wr_mask = '0;
  logic [1:0]         wr_width = '0, srch_width = '0;
  logic [GMR_AW-1:0]  srch_gmr = '0;
  logic [KEY_W-1:0]   srch_key = '0;
  logic srch_ready, res_valid, res_hit;
  logic [IDX_W-1:0] res_index;

  int checks = 0, errors = 0;

  localparam logic [67:0] VA  = 68'h1_2345_6789_ABCD_EF01;
  localparam logic [67:0] VB0 = 68'hA_AAAA_0000_1111_2222;
  localparam logic [67:0] VB1 = 68'h5_5555_3333_4444_6666;
  localparam logic [67:0] VE  = 68'h3_0F0F_0F0F_0F0F_0F0F;
  localparam logic [67:0] VF  = 68'h7_1357_9BDF_2468_ACE0;
  localparam logic [33:0] H0  = 34'h1_2345_6789;
  localparam logic [33:0] H1  = 34'h2_AAAA_5555;

  tsa_search_array #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .GMR_N(GMR_N)) i_tsa_search_array (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_gmr(wr_gmr), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .wr_width(wr_width), .wr_valid(wr_valid),
    .srch_valid(srch_valid), .srch_width(srch_width), .srch_gmr(srch_gmr),
    .srch_key(srch_key), .srch_ready(srch_ready), .res_valid(res_valid),
    .res_hit(res_hit), .res_index(res_index)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_res(input string req, input bit hit, input int idx);
    check(res_valid === 1'b1, req, int'(res_valid), 1);
    check(res_hit === hit, req, int'(res_hit), int'(hit));
    check(res_index === IDX_W'(idx), req, int'(res_index), idx);
  endtask

  task automatic write_slot(input int a, input logic [67:0] d, input logic [67:0] m,
                            input logic [1:0] w, input bit v);
    @(negedge clk);
    wr_en = 1; wr_gmr = 0; wr_addr = SLOT_AW'(a); wr_data = d; wr_mask = m;
    wr_width = w; wr_valid = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic write_gmr(input int a, input logic [67:0] d);
    @(negedge clk);
    wr_en = 1; wr_gmr = 1; wr_addr = SLOT_AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_gmr = 0;
  endtask

  task automatic drive_search(input logic [1:0] w, input int g, input logic [KEY_W-1:0] k);
    srch_valid = 1; srch_width = w; srch_gmr = GMR_AW'(g); srch_key = k;
  endtask

  // issue at a negedge, result sampled at the negedge after the third edge
  task automatic search(input string req, input logic [1:0] w, input int g,
                        input logic [KEY_W-1:0] k, input bit hit, input int idx);
    @(negedge clk);
    while (!srch_ready) @(negedge clk);
    drive_search(w, g, k);
    @(negedge clk);
    srch_valid = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check_res(req, hit, idx);
  endtask

  task automatic t_reset;
    check(srch_ready === 1'b1, "R11 ready", int'(srch_ready), 1);
    check(res_valid === 1'b0, "R11 res_valid", int'(res_valid), 0);
    search("R11 empty bank", 2'd1, 0, '0, 0, 0);
  endtask

  task automatic t_exact_and_ternary;
    write_slot(3, VA, '1, 2'd1, 1);
    search("R1 exact 68", 2'd1, 0, KEY_W'(VA), 1, 3);
    search("R12 miss", 2'd1, 0, KEY_W'(VA ^ 68'h4), 0, 0);
    write_slot(5, VA, ~68'hFF, 2'd1, 1);
    search("R5 lowest of two", 2'd1, 0, KEY_W'(VA), 1, 3);
    search("R1 dont-care bits", 2'd1, 0, KEY_W'(VA ^ 68'h81), 1, 5);
  endtask

  task automatic t_gmr;
    write_gmr(1, ~68'hFFFF);
    search("R4 gmr excludes", 2'd1, 1, KEY_W'(VA ^ 68'hFF00), 1, 3);
    search("R4 gmr0 full", 2'd1, 0, KEY_W'(VA ^ 68'hFF00), 0, 0);
  endtask

  task automatic t_wide;
    write_slot(8, VB0, '1, 2'd2, 1);
    write_slot(9, VB1, '1, 2'd2, 1);
    search("R2 136 hit", 2'd2, 0, KEY_W'({VB1, VB0}), 1, 4);
    search("R2 136 wrong half", 2'd2, 0, KEY_W'({VB0, VB0}), 0, 0);
    search("R6 other width", 2'd1, 0, KEY_W'(VB0), 0, 0);
    write_slot(10, VF, '1, 2'd2, 1);
    search("R2 partial group", 2'd2, 0, KEY_W'({VF, VF}), 0, 0);
    for (int j = 0; j < 4; j++)
      write_slot(12 + j, {4'(j), 64'hFEED_BEEF_0000_0000}, '1, 2'd3, 1);
    search("R2 272 hit", 2'd3, 0,
           {4'd3, 64'hFEED_BEEF_0000_0000, 4'd2, 64'hFEED_BEEF_0000_0000,
            4'd1, 64'hFEED_BEEF_0000_0000, 4'd0, 64'hFEED_BEEF_0000_0000}, 1, 3);
  endtask

  task automatic t_narrow;
    write_slot(1, {H1, H0}, '1, 2'd0, 1);
    search("R3 upper half", 2'd0, 0, KEY_W'(H1), 1, 3);
    search("R3 lower half", 2'd0, 0, KEY_W'(H0), 1, 2);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    drive_search(2'd1, 0, KEY_W'(VA));
    @(negedge clk);
    check(srch_ready === 1'b1, "R8 ready after 68", int'(srch_ready), 1);
    drive_search(2'd2, 0, KEY_W'({VB1, VB0}));
    @(negedge clk);
    check(srch_ready === 1'b1, "R8 ready after 136", int'(srch_ready), 1);
    srch_valid = 0;
    @(negedge clk);
    check_res("R7 first of pair", 1, 3);
    @(negedge clk);
    check_res("R7 second of pair", 1, 4);
  endtask

  task automatic t_gap_and_ignore;
    @(negedge clk);
    drive_search(2'd3, 0, '0);
    @(negedge clk);
    check(srch_ready === 1'b0, "R8 idle after 272", int'(srch_ready), 0);
    drive_search(2'd1, 0, KEY_W'(VA));
    @(negedge clk);
    srch_valid = 0;
    check(srch_ready === 1'b1, "R8 ready back", int'(srch_ready), 1);
    @(negedge clk);
    check_res("R7 272 miss result", 0, 0);
    @(negedge clk);
    check(res_valid === 1'b0, "R9 refused search", int'(res_valid), 0);
  endtask

  task automatic t_write_order;
    write_slot(7, VE, '1, 2'd1, 1);
    @(negedge clk);
    wr_en = 1; wr_gmr = 0; wr_addr = 6; wr_data = VF; wr_mask = '1;
    wr_width = 2'd1; wr_valid = 1;
    @(negedge clk);
    wr_en = 0;
    drive_search(2'd1, 0, KEY_W'(VF));
    @(negedge clk);
    drive_search(2'd1, 0, KEY_W'(VE));
    @(negedge clk);
    srch_valid = 0;
    wr_en = 1; wr_addr = 7; wr_data = VE ^ 68'h1;
    @(negedge clk);
    wr_en = 0;
    check_res("R10 sees prior write", 1, 6);
    @(negedge clk);
    check_res("R10 later write no effect", 1, 7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_exact_and_ternary();
    t_gmr();
    t_wide();
    t_narrow();
    t_back_to_back();
    t_gap_and_ignore();
    t_write_order();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule